// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Processor Core

This block is a small processor with one 32-bit accumulator. It runs a program held in an external word-addressed memory of 256 words. The program counter addresses each instruction word. That word is latched into an instruction register, which splits it into a 4-bit operation code and an operand address. The memory address then switches from the program counter to that operand address. One arithmetic, logic, shift or transfer operation runs against the accumulator, and the result either returns to the accumulator or goes back to memory.

Every instruction takes three cycles of the execution clock: fetch, execute and write-back. The ALU result is captured on the rising edge that closes execute. The accumulator takes it on the falling edge in the middle of write-back, so a store or a following instruction always sees a settled value. A halt instruction parks the core until reset.

The memory side is a plain strobe interface with no valid/ready handshake and no back-pressure. The memory must return the addressed word within the same cycle that the read strobe is high. It must accept a write at the rising edge that ends a cycle in which the write strobe is high. The two data directions are carried on separate buses. The outgoing bus is driven to zero whenever no write is in progress.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, the core clears the program counter to 0 and the accumulator to 0. It shows the fetch phase (`fetch_ph`=1, `mem_rd`=1, `mem_wr`=0, `mem_addr`=0) with `halted`=0.
- R2: The operation code sits in bits 31:28 of an instruction word and the operand address in bits 7:0. Bits 27:8 have no effect.
- R3: Each instruction occupies exactly three cycles: fetch, execute, write-back. `fetch_ph` is high only in the fetch cycle. A halt placed at instruction index k raises `halted` after rising edge 3k+2 counted from reset release, and not before.
- R4: During fetch, `mem_addr` equals the program counter. During execute and write-back, it equals the operand address of the latched instruction.
- R5: The program counter advances by one at the end of every fetch. It changes otherwise only through jump or skip.
- R6: Code 0000 adds the operand to the accumulator, 0001 subtracts the operand, 0010 ANDs, 0011 ORs and 0100 XORs, all modulo 2^32.
- R7: Code 0101 shifts the accumulator left by one and code 0110 shifts it right by one. Both are logical, fill with zero and ignore the operand.
- R8: Code 1101 loads the operand into the accumulator. Code 1110 stores the accumulator in write-back with `mem_wr`=1, `mem_rd`=0 and `mem_wdata` equal to the accumulator. `mem_rd` and `mem_wr` are never high together, and `mem_wr` is high for no other code.
- R9: Code 0111 loads the operand address into the program counter, so the next fetch comes from that address.
- R10: Code 1000 skips the next instruction when the accumulator is zero and does nothing otherwise.
- R11: Code 1001 raises `halted` and holds it until reset. While halted, both strobes are low, `mem_addr` stays frozen at the program counter, and no later instruction runs.
- R12: Codes 1010, 1011, 1100 and 1111 leave the accumulator, the memory and the instruction order unchanged.
- R13: The ALU result is registered on the rising edge that ends execute. The accumulator changes only on the falling edge inside a write-back cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Execution clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 32 | Word returned by memory for `mem_addr` |
| mem_addr | output | 8 | Word address: program counter in fetch, operand address otherwise |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, high only in write-back of a store |
| mem_wdata | output | 32 | Accumulator value during a store, zero otherwise |
| fetch_ph | output | 1 | High during the fetch cycle |
| halted | output | 1 | High from the halt instruction until reset |

## Verification
The assertions check, on every cycle, the properties that hold locally in time:
- the strobes are never both high, and a write strobe appears only for a store;
- the address mux follows the program counter in fetch;
- the program counter advances after each fetch, and a jump lands on its operand address;
- the fetch cycle never repeats back to back;
- halt holds and stays quiet;
- the accumulator moves only on a falling edge inside write-back.

Only the directed programs can show that the ALU computes the right values, including wrap-around and shift fill. The same holds for the skip decision on a zero accumulator, for unused codes and ignored instruction bits leaving the state alone, and for the exact edge on which `halted` rises. They also show that a reset in the middle of a run clears an accumulator that was already loaded.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_WB    = 2'd2,
    PH_HALT  = 2'd3
  } phase_e;

  localparam logic [OPC_W-1:0] OP_ADD = 4'h0;
  localparam logic [OPC_W-1:0] OP_SUB = 4'h1;
  localparam logic [OPC_W-1:0] OP_AND = 4'h2;
  localparam logic [OPC_W-1:0] OP_OR  = 4'h3;
  localparam logic [OPC_W-1:0] OP_XOR = 4'h4;
  localparam logic [OPC_W-1:0] OP_SHL = 4'h5;
  localparam logic [OPC_W-1:0] OP_SHR = 4'h6;
  localparam logic [OPC_W-1:0] OP_JMP = 4'h7;
  localparam logic [OPC_W-1:0] OP_SKZ = 4'h8;
  localparam logic [OPC_W-1:0] OP_HLT = 4'h9;
  localparam logic [OPC_W-1:0] OP_LDA = 4'hD;
  localparam logic [OPC_W-1:0] OP_STA = 4'hE;

  // Operations that fetch a memory operand during execute
  function automatic logic op_reads(input logic [OPC_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_XOR) || (op == OP_LDA);
  endfunction

  // Operations whose result is committed to the accumulator
  function automatic logic op_writes_acc(input logic [OPC_W-1:0] op);
    return op_reads(op) || (op == OP_SHL) || (op == OP_SHR);
  endfunction

endpackage

// File: rtl/acc_seq.sv
module acc_seq
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] op,
  output phase_e           phase
);

  phase_e phase_nx;

  always_comb begin
    unique case (phase)
      PH_FETCH: phase_nx = PH_EXEC;
      PH_EXEC:  phase_nx = (op == OP_HLT) ? PH_HALT : PH_WB;
      PH_WB:    phase_nx = PH_FETCH;
      default:  phase_nx = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_FETCH;
    else        phase <= phase_nx;
  end

endmodule

// File: rtl/acc_fetch.sv
module acc_fetch
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [OPC_W-1:0]  rd_op,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              acc_zero,
  output logic [OPC_W-1:0]  ir_op,
  output logic [ADDR_W-1:0] ir_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mem_addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic ir_ld;
  assign ir_ld = (phase == PH_FETCH);

  // Instruction register: opcode and operand address only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_op   <= '0;
      ir_addr <= '0;
    end else if (ir_ld) begin
      ir_op   <= rd_op;
      ir_addr <= rd_addr;
    end
  end

  // Program counter: step on fetch, redirect on jump or taken skip
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (phase == PH_FETCH) begin
      pc <= pc + ONE;
    end else if (phase == PH_EXEC) begin
      if (ir_op == OP_JMP)                 pc <= ir_addr;
      else if (ir_op == OP_SKZ && acc_zero) pc <= pc + ONE;
    end
  end

  assign mem_addr = (phase == PH_EXEC || phase == PH_WB) ? ir_addr : pc;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] res_q
);

  logic [DATA_W-1:0] res_d;

  always_comb begin
    case (op)
      OP_ADD:  res_d = acc + opnd;
      OP_SUB:  res_d = acc - opnd;
      OP_AND:  res_d = acc & opnd;
      OP_OR:   res_d = acc | opnd;
      OP_XOR:  res_d = acc ^ opnd;
      OP_SHL:  res_d = {acc[DATA_W-2:0], 1'b0};
      OP_SHR:  res_d = {1'b0, acc[DATA_W-1:1]};
      OP_LDA:  res_d = opnd;
      default: res_d = acc;
    endcase
  end

  // Result captured on the rising edge that closes execute
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  res_q <= '0;
    else if (en) res_q <= res_d;
  end

endmodule

// File: rtl/acc_accum.sv
module acc_accum #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  // Commit on the falling edge, half a cycle after the ALU register
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              fetch_ph,
  output logic              halted
);

  phase_e            phase;
  logic [OPC_W-1:0]  ir_op;
  logic [ADDR_W-1:0] ir_addr;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] alu_q;
  logic              acc_zero;
  logic              acc_ld;

  assign acc_zero = (acc == '0);
  assign acc_ld   = (phase == PH_WB) && op_writes_acc(ir_op);

  acc_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (ir_op),
    .phase (phase)
  );

  acc_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .rd_op    (mem_rdata[DATA_W-1 -: OPC_W]),
    .rd_addr  (mem_rdata[ADDR_W-1:0]),
    .acc_zero (acc_zero),
    .ir_op    (ir_op),
    .ir_addr  (ir_addr),
    .pc       (pc),
    .mem_addr (mem_addr)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (phase == PH_EXEC),
    .op    (ir_op),
    .acc   (acc),
    .opnd  (mem_rdata),
    .res_q (alu_q)
  );

  acc_accum #(.DATA_W(DATA_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (acc_ld),
    .d     (alu_q),
    .q     (acc)
  );

  assign mem_rd    = (phase == PH_FETCH) || (phase == PH_EXEC && op_reads(ir_op));
  assign mem_wr    = (phase == PH_WB) && (ir_op == OP_STA);
  assign mem_wdata = mem_wr ? acc : '0;
  assign fetch_ph  = (phase == PH_FETCH);
  assign halted    = (phase == PH_HALT);

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input logic [OPC_W-1:0]  ir_op,
  input logic [ADDR_W-1:0] ir_addr,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              fetch_ph,
  input logic              halted
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R8

  AST_WR_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (ir_op == OP_STA)); // R8

  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ph |-> (mem_addr == pc && mem_rd)); // R4

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ph |=> (pc == $past(pc) + ADDR_W'(1))); // R5

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && ir_op == OP_JMP) |=> (pc == $past(ir_addr))); // R9

  AST_NO_DOUBLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ph |=> !fetch_ph); // R3

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R11

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr && !fetch_ph)); // R11

  AST_ACC_FALL_WB: assert property (@(negedge clk) disable iff (!rst_n)
    !$past(phase == PH_WB) |-> $stable(acc)); // R13

endmodule

bind acc_cpu_core acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase),
  .ir_op    (ir_op),
  .ir_addr  (ir_addr),
  .pc       (pc),
  .acc      (acc),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .fetch_ph (fetch_ph),
  .halted   (halted)
);

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;

  localparam int CLK_P = 10;

  localparam logic [3:0] C_ADD = 4'h0, C_SUB = 4'h1, C_AND = 4'h2, C_OR  = 4'h3;
  localparam logic [3:0] C_XOR = 4'h4, C_SHL = 4'h5, C_SHR = 4'h6, C_JMP = 4'h7;
  localparam logic [3:0] C_SKZ = 4'h8, C_HLT = 4'h9, C_LDA = 4'hD, C_STA = 4'hE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_rdata;
  logic [7:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_wdata;
  logic        fetch_ph, halted;

  logic [31:0] mem [0:255];

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  acc_cpu_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .fetch_ph  (fetch_ph),
    .halted    (halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  function automatic logic [31:0] ins(input logic [3:0] op, input logic [7:0] a);
    return {op, 20'h0, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      #1;
      if (halted) break;
    end
    chk("R11 halt reached", {31'h0, halted}, 32'h1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(posedge clk);
    #(CLK_P/4);
    chk("R1 fetch_ph", {31'h0, fetch_ph}, 32'h1);
    chk("R1 addr", {24'h0, mem_addr}, 32'h0);
    chk("R1 strobes", {30'h0, mem_rd, mem_wr}, 32'h2);
    chk("R1 halted", {31'h0, halted}, 32'h0);
  endtask

  task automatic t_phase();
    clear_mem();
    mem[0] = ins(C_LDA, 8'd100);
    mem[1] = ins(C_STA, 8'd200);
    mem[2] = ins(C_HLT, 8'd0);
    mem[100] = 32'h0000_0011;
    do_reset();
    #1;
    chk("R4 fetch addr is pc", {24'h0, mem_addr}, 32'h0);
    @(posedge clk); #1;
    chk("R3 exec not fetch", {31'h0, fetch_ph}, 32'h0);
    chk("R4 exec addr is operand", {24'h0, mem_addr}, 32'd100);
    chk("R8 lda reads", {31'h0, mem_rd}, 32'h1);
    @(posedge clk); #1;
    chk("R3 wb not fetch", {31'h0, fetch_ph}, 32'h0);
    chk("R4 wb addr", {24'h0, mem_addr}, 32'd100);
    @(posedge clk); #1;
    chk("R3 next fetch", {31'h0, fetch_ph}, 32'h1);
    chk("R5 pc advanced", {24'h0, mem_addr}, 32'h1);
    @(posedge clk); @(posedge clk); #1;
    chk("R8 store strobes", {30'h0, mem_rd, mem_wr}, 32'h1);
    chk("R13 store data is loaded acc", mem_wdata, 32'h0000_0011);
    run_to_halt();
    chk("R8 stored word", mem[200], 32'h0000_0011);
  endtask

  task automatic t_alu();
    clear_mem();
    mem[0]  = ins(C_LDA, 8'd100);
    mem[1]  = ins(C_ADD, 8'd101);
    mem[2]  = ins(C_SUB, 8'd102);
    mem[3]  = ins(C_STA, 8'd200);
    mem[4]  = ins(C_AND, 8'd103);
    mem[5]  = ins(C_STA, 8'd201);
    mem[6]  = ins(C_OR,  8'd104);
    mem[7]  = ins(C_STA, 8'd202);
    mem[8]  = ins(C_XOR, 8'd105);
    mem[9]  = ins(C_STA, 8'd203);
    mem[10] = ins(C_LDA, 8'd106);
    mem[11] = ins(C_SUB, 8'd107);
    mem[12] = ins(C_STA, 8'd204);
    mem[13] = ins(C_ADD, 8'd106);
    mem[14] = ins(C_STA, 8'd205);
    mem[15] = ins(C_LDA, 8'd108);
    mem[16] = ins(C_SHL, 8'd101);
    mem[17] = ins(C_STA, 8'd206);
    mem[18] = ins(C_LDA, 8'd108);
    mem[19] = ins(C_SHR, 8'd101);
    mem[20] = ins(C_STA, 8'd207);
    mem[21] = ins(C_HLT, 8'd0);
    mem[100] = 32'd5;  mem[101] = 32'd7;  mem[102] = 32'd3;
    mem[103] = 32'hC;  mem[104] = 32'h3;  mem[105] = 32'hF;
    mem[106] = 32'd1;  mem[107] = 32'd2;  mem[108] = 32'h8000_0001;
    mem[205] = 32'h1234;
    do_reset();
    run_to_halt();
    chk("R6 add then sub", mem[200], 32'd9);
    chk("R6 and", mem[201], 32'd8);
    chk("R6 or", mem[202], 32'hB);
    chk("R6 xor", mem[203], 32'h4);
    chk("R6 sub wraps", mem[204], 32'hFFFF_FFFF);
    chk("R6 add wraps", mem[205], 32'h0);
    chk("R7 shift left", mem[206], 32'h0000_0002);
    chk("R7 shift right", mem[207], 32'h4000_0000);
  endtask

  task automatic t_branch();
    clear_mem();
    mem[0] = ins(C_LDA, 8'd100);
    mem[1] = ins(C_SKZ, 8'd0);
    mem[2] = ins(C_STA, 8'd200);
    mem[3] = ins(C_LDA, 8'd101);
    mem[4] = ins(C_SKZ, 8'd0);
    mem[5] = ins(C_STA, 8'd201);
    mem[6] = ins(C_JMP, 8'd8);
    mem[7] = ins(C_STA, 8'd202);
    mem[8] = ins(C_HLT, 8'd0);
    mem[100] = 32'd0; mem[101] = 32'd9;
    mem[200] = 32'hDEAD; mem[201] = 32'hDEAD; mem[202] = 32'hDEAD;
    do_reset();
    run_to_halt();
    chk("R10 skip taken on zero", mem[200], 32'hDEAD);
    chk("R10 no skip on nonzero", mem[201], 32'd9);
    chk("R9 jump bypasses store", mem[202], 32'hDEAD);
    chk("R9 halt at jump target", {24'h0, mem_addr}, 32'd9);
  endtask

  task automatic t_halt();
    logic bad;
    clear_mem();
    mem[0] = ins(C_LDA, 8'd100);
    mem[1] = ins(C_HLT, 8'd0);
    mem[2] = ins(C_STA, 8'd200);
    mem[100] = 32'h77;
    mem[200] = 32'hBEEF;
    do_reset();
    run_to_halt();
    bad = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !halted || mem_addr != 8'd2) bad = 1'b1;
    end
    chk("R11 quiet and frozen", {31'h0, bad}, 32'h0);
    chk("R11 later store not run", mem[200], 32'hBEEF);
  endtask

  task automatic t_timing();
    clear_mem();
    mem[0] = ins(4'hA, 8'd0);
    mem[1] = ins(4'hB, 8'd0);
    mem[2] = ins(C_HLT, 8'd0);
    do_reset();
    repeat (7) @(posedge clk);
    #1;
    chk("R3 not halted after edge 7", {31'h0, halted}, 32'h0);
    @(posedge clk); #1;
    chk("R3 halted after edge 8", {31'h0, halted}, 32'h1);
  endtask

  task automatic t_nop();
    clear_mem();
    mem[0] = ins(C_LDA, 8'd100);
    mem[1] = ins(4'hA, 8'd101);
    mem[2] = ins(4'hB, 8'd101);
    mem[3] = ins(4'hC, 8'd101);
    mem[4] = ins(4'hF, 8'd101);
    mem[5] = ins(C_STA, 8'd200);
    mem[6] = ins(C_ADD, 8'd101) | 32'h0ABC_DE00;
    mem[7] = ins(C_STA, 8'd201);
    mem[8] = ins(C_HLT, 8'd0);
    mem[100] = 32'h55; mem[101] = 32'h1;
    do_reset();
    run_to_halt();
    chk("R12 unused codes no effect", mem[200], 32'h55);
    chk("R12 unused codes keep memory", mem[101], 32'h1);
    chk("R2 middle bits ignored", mem[201], 32'h56);
  endtask

  task automatic t_rerun();
    clear_mem();
    mem[0] = ins(C_LDA, 8'd100);
    mem[1] = ins(C_HLT, 8'd0);
    mem[100] = 32'hA5A5;
    do_reset();
    run_to_halt();
    mem[0] = ins(C_STA, 8'd210);
    mem[210] = 32'hAAAA;
    do_reset();
    run_to_halt();
    chk("R1 reset clears acc", mem[210], 32'h0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_mem();
    t_reset();
    t_phase();
    t_alu();
    t_branch();
    t_halt();
    t_timing();
    t_nop();
    t_rerun();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule